// File: doc/BRIEF.md
# Selectable-Ratio Clock Bank Divider

This block takes a fast oscillator clock and produces a bank of nine matched output clocks plus one feedback clock. All ten run at the fast clock divided by an even ratio that a 3-bit select picks, and all switch on the same fast clock edge. A companion clock runs at half the divided rate. Its edges line up with the rising edges of the bank.

One select code is a single-step test setting. In that setting the divider is bypassed: a separate reference clock drives the bank and the feedback output directly, and the companion clock becomes that reference divided by two. Unused codes silence every output and raise an invalid-mode flag. Any change of select, and any synchronous reset, restarts the divider from a clean low phase, so no shortened pulse appears at a ratio switch.

Top module: `clk_ratio_bank`

## Requirements
- R1: Select 3'b111 divides by 12, 3'b110 by 10, 3'b100 by 8 and 3'b011 by 6. The divided clock is high for exactly half the ratio in fast cycles and low for the other half.
- R2: The nine bank outputs always equal the feedback output, bit for bit.
- R3: In a dividing mode, the half-rate output toggles on each rising edge of the divided clock and at no other time.
- R4: Select 3'b101 routes the reference clock combinationally to all nine bank outputs and to the feedback output.
- R5: Under select 3'b101, the half-rate output toggles on each rising edge of the reference clock, starting low.
- R6: Selects 3'b000, 3'b001 and 3'b010 hold the bank, the feedback and the half-rate outputs low and drive the invalid flag high. Every other code drives the flag low.
- R7: On the first fast edge after the select changes, the divided and half-rate clocks go low. The first rising edge follows exactly half the new ratio in fast edges later.
- R8: A synchronous active-high reset clears the divided and half-rate clocks on the fast edge where it is sampled. Division restarts from that edge exactly as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastClk | input | 1 | Fast oscillator clock feeding the divider |
| refClk | input | 1 | Reference / single-step test clock |
| rst | input | 1 | Synchronous active-high reset, fast domain (also clears the test half-rate flop on a reference edge) |
| modeSel | input | 3 | Ratio / test / invalid select code |
| qOut | output | 9 | Matched bank of output clocks |
| fbOut | output | 1 | Feedback clock, same as the bank |
| halfOut | output | 1 | Half-rate companion clock |
| modeBad | output | 1 | High while the select code is unused |

## Verification
In the dividing modes every output comes from one register stage on the fast clock. A select change or a reset therefore takes effect on the next rising fast edge, and that edge is counted as edge zero. The bench changes inputs on falling edges and samples on the next falling edge. It numbers each edge k from the restart and expects the divided level floor(k/h) mod 2 and the half-rate level floor((k+h)/(2h)) mod 2, where h is half the ratio. In test mode the bank follows the reference clock with no register in the path, so the bench checks it one time unit after each reference transition. The invalid flag depends only on the select code and is checked in the same sample as the outputs.

// File: rtl/clk_ratio_bank_pkg.sv
package clk_ratio_bank_pkg;

  typedef enum logic [2:0] {
    SEL_DIV12 = 3'b111,
    SEL_DIV10 = 3'b110,
    SEL_DIV8  = 3'b100,
    SEL_DIV6  = 3'b011,
    SEL_STEP  = 3'b101
  } selCode_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic restart;  // clear divided and half-rate flops
    logic toggle;   // divided clock flips on this edge
    logic bypass;   // reference clock drives the outputs
    logic quiet;    // unused code: outputs held low
  } bankCtl_t;

  // half of the division ratio for a select code, 0 when not dividing
  function automatic int halfRatioOf(input logic [2:0] code);
    case (code)
      SEL_DIV12: return 6;
      SEL_DIV10: return 5;
      SEL_DIV8:  return 4;
      SEL_DIV6:  return 3;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/clk_ratio_bank_ctrl.sv
module clk_ratio_bank_ctrl
  import clk_ratio_bank_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             fastClk,
  input  logic             rst,
  input  logic [SEL_W-1:0] modeSel,
  output bankCtl_t         ctl
);

  logic [SEL_W-1:0] selPrev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfCnt;
  logic             dividing;
  logic             selMoved;

  always_comb begin
    halfCnt  = CNT_W'(halfRatioOf(3'(modeSel)));
    dividing = (halfCnt != '0);
    selMoved = (modeSel != selPrev);
    ctl.bypass  = (modeSel == SEL_W'(SEL_STEP));
    ctl.quiet   = !dividing && !ctl.bypass;
    ctl.restart = rst || selMoved || !dividing;
    ctl.toggle  = !ctl.restart && (cnt == halfCnt - CNT_W'(1));
  end

  always_ff @(posedge fastClk) begin
    selPrev <= modeSel;
    if (ctl.restart || ctl.toggle) cnt <= '0;
    else                           cnt <= cnt + CNT_W'(1);
  end

  // counter never reaches the half ratio while dividing (R1)
  assert_cnt_bound_R1: assert property (@(posedge fastClk) disable iff (rst)
    (dividing && !selMoved) |-> (cnt < halfCnt));

endmodule

// File: rtl/clk_ratio_bank_dp.sv
module clk_ratio_bank_dp
  import clk_ratio_bank_pkg::*;
#(
  parameter int NUM_Q = 9
) (
  input  logic             fastClk,
  input  logic             refClk,
  input  logic             rst,
  input  bankCtl_t         ctl,
  output logic [NUM_Q-1:0] qOut,
  output logic             fbOut,
  output logic             halfOut
);

  logic divReg;
  logic halfReg;
  logic refHalf;
  logic mainClk;

  always_ff @(posedge fastClk) begin
    if (ctl.restart) begin
      divReg  <= 1'b0;
      halfReg <= 1'b0;
    end else if (ctl.toggle) begin
      divReg <= !divReg;
      if (!divReg) halfReg <= !halfReg;
    end
  end

  // test-mode half-rate flop lives on the reference clock
  always_ff @(posedge refClk) begin
    if (rst || !ctl.bypass) refHalf <= 1'b0;
    else                    refHalf <= !refHalf;
  end

  always_comb begin
    if (ctl.bypass) begin
      mainClk = refClk;
      halfOut = refHalf;
    end else if (ctl.quiet) begin
      mainClk = 1'b0;
      halfOut = 1'b0;
    end else begin
      mainClk = divReg;
      halfOut = halfReg;
    end
  end

  generate
    for (genvar i = 0; i < NUM_Q; i++) begin : g_bank
      assign qOut[i] = mainClk;
    end
  endgenerate
  assign fbOut = mainClk;

  assert_restart_clear_R7: assert property (@(posedge fastClk)
    ctl.restart |=> (!divReg && !halfReg));

  assert_half_on_rise_R3: assert property (@(posedge fastClk) disable iff (rst)
    (!$past(ctl.restart) && $rose(divReg)) |-> (halfReg != $past(halfReg)));

  assert_div_edge_gated_R1: assert property (@(posedge fastClk) disable iff (rst)
    (!$past(ctl.restart) && (divReg != $past(divReg))) |-> $past(ctl.toggle));

  assert_ref_half_R5: assert property (@(posedge refClk) disable iff (rst)
    ctl.bypass |=> (refHalf != $past(refHalf)));

endmodule

// File: rtl/clk_ratio_bank.sv
module clk_ratio_bank
  import clk_ratio_bank_pkg::*;
#(
  parameter int NUM_Q = 9,
  parameter int SEL_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             fastClk,
  input  logic             refClk,
  input  logic             rst,
  input  logic [SEL_W-1:0] modeSel,
  output logic [NUM_Q-1:0] qOut,
  output logic             fbOut,
  output logic             halfOut,
  output logic             modeBad
);

  bankCtl_t ctl;

  clk_ratio_bank_ctrl #(.SEL_W(SEL_W), .CNT_W(CNT_W)) ctrl_i (
    .fastClk (fastClk),
    .rst     (rst),
    .modeSel (modeSel),
    .ctl     (ctl)
  );

  clk_ratio_bank_dp #(.NUM_Q(NUM_Q)) dp_i (
    .fastClk (fastClk),
    .refClk  (refClk),
    .rst     (rst),
    .ctl     (ctl),
    .qOut    (qOut),
    .fbOut   (fbOut),
    .halfOut (halfOut)
  );

  assign modeBad = ctl.quiet;

  assert_invalid_quiet_R6: assert property (@(posedge fastClk)
    modeBad |-> (qOut == '0 && !fbOut && !halfOut));

  assert_bank_match_R2: assert property (@(posedge fastClk)
    qOut == {NUM_Q{fbOut}});

endmodule

// File: tb/clk_ratio_bank_tb_top.sv
module clk_ratio_bank_tb_top;

  localparam int NUM_Q = 9;

  logic             fastClk = 1'b0;
  logic             refClk  = 1'b0;
  logic             rst     = 1'b1;
  logic [2:0]       modeSel = 3'b000;
  logic [NUM_Q-1:0] qOut;
  logic             fbOut;
  logic             halfOut;
  logic             modeBad;

  int checks = 0;
  int failures = 0;

  always #10 fastClk = !fastClk;  // 50 MHz

  clk_ratio_bank dut_i (
    .fastClk (fastClk),
    .refClk  (refClk),
    .rst     (rst),
    .modeSel (modeSel),
    .qOut    (qOut),
    .fbOut   (fbOut),
    .halfOut (halfOut),
    .modeBad (modeBad)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // sample n falling edges, edge index k counted from the restart edge
  task automatic follow(input int h, input int k0, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int k;
      logic expDiv;
      logic expHalf;
      @(negedge fastClk);
      k = k0 + i;
      expDiv  = ((k / h) % 2) == 1;
      expHalf = (((k + h) / (2 * h)) % 2) == 1;
      check({req, " div"}, 32'(fbOut), 32'(expDiv));
      check({req, " half R3"}, 32'(halfOut), 32'(expHalf));
      check("R2 bank match", 32'(qOut), 32'({NUM_Q{fbOut}}));
      check("R6 flag low", 32'(modeBad), 32'(0));
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2:0] codes [4] = '{3'b111, 3'b110, 3'b100, 3'b011};
    int halves [4] = '{6, 5, 4, 3};
    logic [2:0] bad [3] = '{3'b000, 3'b001, 3'b010};

    // reset with an unused code, one reference pulse clears the test flop
    repeat (2) @(posedge fastClk);
    refClk = 1'b1; #2; refClk = 1'b0;
    @(negedge fastClk);
    check("R8 reset q", 32'(qOut), 32'(0));
    check("R8 reset fb", 32'(fbOut), 32'(0));
    check("R8 reset half", 32'(halfOut), 32'(0));
    check("R6 flag at reset", 32'(modeBad), 32'(1));

    // R1 / R7: each ratio, switched mid-phase from the previous one
    rst = 1'b0;
    for (int m = 0; m < 4; m++) begin
      modeSel = codes[m];
      follow(halves[m], 0, 8 * halves[m] + 3, "R1 R7 ratio");
    end

    // R8: mid-run reset in the divide-by-8 setting
    modeSel = 3'b100;
    follow(4, 0, 5, "R7 enter div8");
    rst = 1'b1;
    follow(4, 0, 1, "R8 reset edge");
    rst = 1'b0;
    follow(4, 1, 24, "R8 after reset");

    // R6: unused codes
    for (int b = 0; b < 3; b++) begin
      modeSel = bad[b];
      for (int i = 0; i < 4; i++) begin
        @(negedge fastClk);
        check("R6 q low", 32'(qOut), 32'(0));
        check("R6 fb low", 32'(fbOut), 32'(0));
        check("R6 half low", 32'(halfOut), 32'(0));
        check("R6 flag high", 32'(modeBad), 32'(1));
      end
    end

    // R4 / R5: single-step test setting
    modeSel = 3'b101;
    #1;
    check("R4 q idle low", 32'(qOut), 32'(0));
    check("R5 half starts low", 32'(halfOut), 32'(0));
    check("R6 flag low in test", 32'(modeBad), 32'(0));
    for (int n = 1; n <= 8; n++) begin
      #7 refClk = 1'b1;
      #1;
      check("R4 q follows high", 32'(qOut), 32'({NUM_Q{1'b1}}));
      check("R4 fb follows high", 32'(fbOut), 32'(1));
      check("R5 half toggle", 32'(halfOut), 32'(n % 2));
      #7 refClk = 1'b0;
      #1;
      check("R4 q follows low", 32'(qOut), 32'(0));
      check("R4 fb follows low", 32'(fbOut), 32'(0));
      check("R5 half hold", 32'(halfOut), 32'(n % 2));
    end

    // R7: leave test setting into divide-by-10
    @(negedge fastClk);
    modeSel = 3'b110;
    follow(5, 0, 30, "R7 exit test");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule